// File: doc/BRIEF.md
# Parallel Multi-Chain Addressable LED Driver

This block drives several chains of single-wire addressable RGB LEDs in lockstep, one output line per chain. It reads a bit-sliced slot store: each slot is one bit period for every chain at once, and bit `i` of a slot tells chain `i` whether that period carries a zero or a one. Each bit period has three phases. All enabled lines rise together at the start. Lines sending a zero fall at an early cut. Every remaining line falls at a late cut.

The host fills the slot store through a simple write port, picks the LED count and the chain mask, and raises the run input. The block then repeats frames with a fixed period. Each frame is an active stretch of `count × 24` bit periods, followed by a low gap that latches the LEDs. The busy output covers the active stretch. The host is expected to rewrite slots only while busy is low, so that no frame goes out with half-updated data.

Top module: `led_chain_driver`

## Requirements
- R1: After reset every LED line and busy are low and every slot byte is zero, so a first frame with no writes sends a one on every enabled chain in every period.
- R2: A bit period lasts BIT_CYCLES clock cycles (default 90). Pulses start BIT_CYCLES apart, and the first pulse of a frame starts one cycle after busy rises.
- R3: A zero bit holds its line high for exactly ZERO_CUT cycles (default 28).
- R4: A one bit holds its line high for exactly ONE_CUT cycles (default 58).
- R5: Slots are sent in ascending address order, LED `n` using addresses `24n` to `24n+23`. Bit `i` of a slot byte set means chain `i` sends a zero, and clear means a one. The host is expected to put green, red and blue in that order, most significant bit first.
- R6: A chain whose mask bit is clear stays low for the whole frame.
- R7: Busy is high for exactly `count × 24 × BIT_CYCLES` cycles at the start of each frame.
- R8: Successive frames start FRAME_CYCLES apart, and every line is low whenever busy is low.
- R9: Nothing is sent while run is low. Busy rises in the cycle after run is first sampled high. Dropping run mid-frame lets the current frame finish, after which the block stays idle.
- R10: The LED count and the chain mask are sampled only at a frame start, so changing them mid-frame takes effect from the next frame.
- R11: An LED count of zero produces no pulses and no busy.
- R12: An LED count above MAX_LEDS is treated as MAX_LEDS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-timing clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Start and keep repeating frames |
| led_count | input | $clog2(MAX_LEDS+1) | LEDs per chain, sampled at frame start |
| chain_mask | input | CHAINS | Chains that are driven, sampled at frame start |
| wr_en | input | 1 | Slot write strobe |
| wr_addr | input | $clog2(MAX_LEDS*24) | Slot address; addresses past the store are ignored |
| wr_data | input | CHAINS | Slot byte, one zero-flag per chain |
| busy | output | 1 | High during the active slots of a frame |
| led_out | output | CHAINS | Serial LED lines |

## Verification
The checker watches every cycle. Rising edges only follow the start phase of a period and falling edges only follow one of the two cuts. Masked chains never go high, and every line is low whenever busy is low. The slot index never passes the frame's slot total. Only the bench scenarios can show the rest: exact pulse widths against the expected bit stream from the slot contents, the busy length and frame period, the reset-cleared store, the clamp of the LED count, and the sampling of count, mask and run at frame boundaries.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

    // Slots per LED: three colours of eight bits each.
    localparam int SLOTS_PER_LED   = 24;

    // Default timing at a 72 MHz clock.
    localparam int DEF_BIT_CYCLES  = 90;
    localparam int DEF_ZERO_CUT    = 28;
    localparam int DEF_ONE_CUT     = 58;
    localparam int DEF_FRAME_CYCLE = 3_600_000;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Level of one line at a given phase of a bit period.
    function automatic logic line_level(input int unsigned phase,
                                        input logic        is_zero,
                                        input int unsigned zero_cut,
                                        input int unsigned one_cut);
        int unsigned cut;
        cut = is_zero ? zero_cut : one_cut;
        return (phase < cut);
    endfunction

    // Saturating LED count.
    function automatic int unsigned clamp_count(input int unsigned cnt,
                                                input int unsigned max_cnt);
        return (cnt > max_cnt) ? max_cnt : cnt;
    endfunction

endpackage

// File: rtl/led_slot_store.sv
module led_slot_store #(
    parameter int CHAINS = 8,
    parameter int DEPTH  = 768,
    parameter int AW     = $clog2(DEPTH),
    parameter int SW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [CHAINS-1:0] wr_data,
    input  logic [SW-1:0]     rd_slot,
    output logic [CHAINS-1:0] rd_data
);

    logic [CHAINS-1:0] mem [DEPTH];
    logic              wr_in_range;
    logic              rd_in_range;

    assign wr_in_range = ({1'b0, wr_addr} < (AW+1)'(DEPTH));
    assign rd_in_range = (rd_slot < SW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) begin
                mem[a] <= '0;
            end
        end else if (wr_en && wr_in_range) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = rd_in_range ? mem[rd_slot[AW-1:0]] : '0;

endmodule

// File: rtl/led_frame_seq.sv
module led_frame_seq
    import led_drv_pkg::*;
#(
    parameter int CHAINS       = 8,
    parameter int MAX_LEDS     = 32,
    parameter int BIT_CYCLES   = DEF_BIT_CYCLES,
    parameter int FRAME_CYCLES = DEF_FRAME_CYCLE,
    parameter int CW           = $clog2(MAX_LEDS + 1),
    parameter int PW           = $clog2(BIT_CYCLES),
    parameter int SW           = $clog2(MAX_LEDS * SLOTS_PER_LED + 1),
    parameter int FW           = $clog2(FRAME_CYCLES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic [CW-1:0]     led_count,
    input  logic [CHAINS-1:0] chain_mask,
    output logic [PW-1:0]     phase,
    output logic [SW-1:0]     slot,
    output logic [SW-1:0]     slot_total,
    output logic [CHAINS-1:0] mask_live,
    output logic              active
);

    localparam logic [PW-1:0] PHASE_LAST = PW'(BIT_CYCLES - 1);
    localparam logic [FW-1:0] FRAME_LAST = FW'(FRAME_CYCLES - 1);

    seq_state_e        state_q;
    logic [FW-1:0]     frame_q;
    logic [PW-1:0]     phase_q;
    logic [SW-1:0]     slot_q;
    logic [SW-1:0]     total_q;
    logic [CHAINS-1:0] mask_q;
    logic [SW-1:0]     total_next;
    logic              frame_end;
    logic              slots_left;

    // Slot count for the next frame, with the LED count saturated.
    always_comb begin
        int unsigned eff;
        eff        = clamp_count(int'(led_count), MAX_LEDS);
        total_next = SW'(eff * SLOTS_PER_LED);
    end

    assign frame_end  = (frame_q == FRAME_LAST);
    assign slots_left = (slot_q < total_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            frame_q <= '0;
            phase_q <= '0;
            slot_q  <= '0;
            total_q <= '0;
            mask_q  <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (run_en) begin
                        state_q <= SEQ_RUN;
                        frame_q <= '0;
                        phase_q <= '0;
                        slot_q  <= '0;
                        total_q <= total_next;
                        mask_q  <= chain_mask;
                    end
                end
                SEQ_RUN: begin
                    if (frame_end) begin
                        frame_q <= '0;
                        phase_q <= '0;
                        slot_q  <= '0;
                        if (run_en) begin
                            total_q <= total_next;
                            mask_q  <= chain_mask;
                        end else begin
                            state_q <= SEQ_IDLE;
                            total_q <= '0;
                        end
                    end else begin
                        frame_q <= frame_q + 1'b1;
                        if (phase_q == PHASE_LAST) begin
                            phase_q <= '0;
                            if (slots_left) begin
                                slot_q <= slot_q + 1'b1;
                            end
                        end else begin
                            phase_q <= phase_q + 1'b1;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign phase      = phase_q;
    assign slot       = slot_q;
    assign slot_total = total_q;
    assign mask_live  = mask_q;
    assign active     = (state_q == SEQ_RUN) && slots_left;

endmodule

// File: rtl/led_pulse_gen.sv
module led_pulse_gen
    import led_drv_pkg::*;
#(
    parameter int CHAINS     = 8,
    parameter int BIT_CYCLES = DEF_BIT_CYCLES,
    parameter int ZERO_CUT   = DEF_ZERO_CUT,
    parameter int ONE_CUT    = DEF_ONE_CUT,
    parameter int PW         = $clog2(BIT_CYCLES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [PW-1:0]     phase,
    input  logic [CHAINS-1:0] mask_live,
    input  logic [CHAINS-1:0] zero_flags,
    output logic [CHAINS-1:0] lines
);

    // One registered output stage per chain.
    for (genvar c = 0; c < CHAINS; c++) begin : g_chain
        logic line_q;
        logic line_d;

        assign line_d = active && mask_live[c] &&
                        line_level(int'(phase), zero_flags[c],
                                   ZERO_CUT, ONE_CUT);

        always_ff @(posedge clk) begin
            if (rst) begin
                line_q <= 1'b0;
            end else begin
                line_q <= line_d;
            end
        end

        assign lines[c] = line_q;
    end

endmodule

// File: rtl/led_chain_driver.sv
module led_chain_driver
    import led_drv_pkg::*;
#(
    parameter int CHAINS       = 8,
    parameter int MAX_LEDS     = 32,
    parameter int BIT_CYCLES   = DEF_BIT_CYCLES,
    parameter int ZERO_CUT     = DEF_ZERO_CUT,
    parameter int ONE_CUT      = DEF_ONE_CUT,
    parameter int FRAME_CYCLES = DEF_FRAME_CYCLE,
    parameter int DEPTH        = MAX_LEDS * SLOTS_PER_LED,
    parameter int CW           = $clog2(MAX_LEDS + 1),
    parameter int AW           = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic [CW-1:0]     led_count,
    input  logic [CHAINS-1:0] chain_mask,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [CHAINS-1:0] wr_data,
    output logic              busy,
    output logic [CHAINS-1:0] led_out
);

    localparam int PW = $clog2(BIT_CYCLES);
    localparam int SW = $clog2(DEPTH + 1);

    logic [PW-1:0]     seq_phase;
    logic [SW-1:0]     seq_slot;
    logic [SW-1:0]     seq_total;
    logic [CHAINS-1:0] seq_mask;
    logic              seq_active;
    logic [CHAINS-1:0] slot_flags;

    led_frame_seq #(
        .CHAINS      (CHAINS),
        .MAX_LEDS    (MAX_LEDS),
        .BIT_CYCLES  (BIT_CYCLES),
        .FRAME_CYCLES(FRAME_CYCLES),
        .CW          (CW),
        .PW          (PW),
        .SW          (SW)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .led_count (led_count),
        .chain_mask(chain_mask),
        .phase     (seq_phase),
        .slot      (seq_slot),
        .slot_total(seq_total),
        .mask_live (seq_mask),
        .active    (seq_active)
    );

    led_slot_store #(
        .CHAINS(CHAINS),
        .DEPTH (DEPTH),
        .AW    (AW),
        .SW    (SW)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_slot(seq_slot),
        .rd_data(slot_flags)
    );

    led_pulse_gen #(
        .CHAINS    (CHAINS),
        .BIT_CYCLES(BIT_CYCLES),
        .ZERO_CUT  (ZERO_CUT),
        .ONE_CUT   (ONE_CUT),
        .PW        (PW)
    ) u_pulse (
        .clk       (clk),
        .rst       (rst),
        .active    (seq_active),
        .phase     (seq_phase),
        .mask_live (seq_mask),
        .zero_flags(slot_flags),
        .lines     (led_out)
    );

    assign busy = seq_active;

endmodule

// File: rtl/led_chain_driver_chk.sv
module led_chain_driver_chk #(
    parameter int CHAINS   = 8,
    parameter int PW       = 7,
    parameter int SW       = 10,
    parameter int ZERO_CUT = 28,
    parameter int ONE_CUT  = 58
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic [CHAINS-1:0] led_out,
    input logic [PW-1:0]     seq_phase,
    input logic [SW-1:0]     seq_slot,
    input logic [SW-1:0]     seq_total,
    input logic [CHAINS-1:0] seq_mask
);

    // R2
    bit_rise_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (|(led_out & ~$past(led_out))) |-> ($past(seq_phase) == '0));

    // R3 R4
    bit_fall_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (|($past(led_out) & ~led_out)) |->
            (($past(seq_phase) == PW'(ZERO_CUT)) ||
             ($past(seq_phase) == PW'(ONE_CUT))));

    // R6
    masked_low_chk: assert property (@(posedge clk) disable iff (rst)
        (led_out & ~seq_mask) == '0);

    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (led_out == '0));

    // R7
    slot_bound_chk: assert property (@(posedge clk) disable iff (rst)
        seq_slot <= seq_total);

endmodule

bind led_chain_driver led_chain_driver_chk #(
    .CHAINS  (CHAINS),
    .PW      (PW),
    .SW      (SW),
    .ZERO_CUT(ZERO_CUT),
    .ONE_CUT (ONE_CUT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .led_out  (led_out),
    .seq_phase(seq_phase),
    .seq_slot (seq_slot),
    .seq_total(seq_total),
    .seq_mask (seq_mask)
);

// File: tb/sim_led_chain_driver.sv
module sim_led_chain_driver;

    localparam int CLK_PERIOD = 10;
    localparam int CH    = 8;
    localparam int MAXL  = 2;
    localparam int BIT   = 90;
    localparam int ZC    = 28;
    localparam int OC    = 58;
    localparam int FRAME = 5000;
    localparam int DEPTH = MAXL * 24;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(MAXL + 1);
    localparam int MAXP  = MAXL * 24;
    localparam int NVEC  = 5;

    // {count[33:32], mask[31:24], colour seed[23:0]}
    localparam logic [33:0] VECS [NVEC] = '{
        {2'd1, 8'hFF, 24'h123456},
        {2'd2, 8'hA5, 24'hF0F00F},
        {2'd2, 8'h01, 24'h5A5A5A},
        {2'd3, 8'hFF, 24'hABCDEF},
        {2'd0, 8'hFF, 24'h000000}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          run_en;
    logic [CW-1:0] led_count;
    logic [CH-1:0] chain_mask;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [CH-1:0] wr_data;
    logic          busy;
    logic [CH-1:0] led_out;

    led_chain_driver #(
        .CHAINS      (CH),
        .MAX_LEDS    (MAXL),
        .BIT_CYCLES  (BIT),
        .ZERO_CUT    (ZC),
        .ONE_CUT     (OC),
        .FRAME_CYCLES(FRAME)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .led_count (led_count),
        .chain_mask(chain_mask),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .busy      (busy),
        .led_out   (led_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int rise_at [CH][MAXP];
    int wid     [CH][MAXP];
    int npulse  [CH];
    int busy_len;
    int low_bad;

    task automatic check(input bit ok, input string req,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [23:0] colour(input int pin, input int l,
                                           input logic [23:0] seed);
        return seed ^ 24'(pin * 24'h01F3A5) ^ 24'(l * 24'h0007C1)
                    ^ 24'((pin * l + 1) * 24'h0000B3);
    endfunction

    // Expected bit: 1 = one, 0 = zero. A blank store sends all ones.
    function automatic bit exp_bit(input int pin, input int l, input int k,
                                   input logic [23:0] seed, input bit blank);
        logic [23:0] c;
        if (blank) return 1'b1;
        c = colour(pin, l, seed);
        return c[23 - k];
    endfunction

    task automatic load(input logic [23:0] seed);
        for (int a = 0; a < DEPTH; a++) begin
            logic [CH-1:0] d;
            for (int p = 0; p < CH; p++) begin
                d[p] = ~exp_bit(p, a / 24, a % 24, seed, 1'b0);
            end
            wr_en   = 1'b1;
            wr_addr = AW'(a);
            wr_data = d;
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic stop_wait();
        run_en = 1'b0;
        repeat (FRAME + 5) @(negedge clk);
    endtask

    task automatic capture(input int chg_at, input logic [CW-1:0] nc,
                           input logic [CH-1:0] nm, input logic nrun);
        logic [CH-1:0] prev;
        int rs [CH];
        int guard;
        guard = 0;
        while (!busy && guard < 3 * FRAME) begin
            @(negedge clk);
            guard++;
        end
        prev     = '0;
        busy_len = 0;
        low_bad  = 0;
        for (int p = 0; p < CH; p++) begin
            npulse[p] = 0;
            rs[p]     = 0;
        end
        for (int s = 0; s < FRAME; s++) begin
            if (s == chg_at) begin
                led_count  = nc;
                chain_mask = nm;
                run_en     = nrun;
            end
            if (busy) busy_len++;
            else if (led_out != '0) low_bad++;
            for (int p = 0; p < CH; p++) begin
                if (led_out[p] && !prev[p]) rs[p] = s;
                if (!led_out[p] && prev[p]) begin
                    if (npulse[p] < MAXP) begin
                        rise_at[p][npulse[p]] = rs[p];
                        wid[p][npulse[p]]     = s - rs[p];
                    end
                    npulse[p]++;
                end
            end
            prev = led_out;
            @(negedge clk);
        end
    endtask

    task automatic verify(input int cnt, input logic [CH-1:0] msk,
                          input logic [23:0] seed, input bit blank,
                          input string tag);
        check(busy_len == cnt * 24 * BIT, {tag, " R7 busy length"},
              busy_len, cnt * 24 * BIT);
        check(low_bad == 0, {tag, " R8 line high outside busy"}, low_bad, 0);
        for (int p = 0; p < CH; p++) begin
            if (!msk[p] || cnt == 0) begin
                check(npulse[p] == 0, {tag, " R6 masked chain pulses"},
                      npulse[p], 0);
            end else begin
                check(npulse[p] == cnt * 24, {tag, " R7 pulse count"},
                      npulse[p], cnt * 24);
                for (int j = 0; j < cnt * 24 && j < npulse[p]; j++) begin
                    bit b;
                    int e;
                    b = exp_bit(p, j / 24, j % 24, seed, blank);
                    e = b ? OC : ZC;
                    check(wid[p][j] == e,
                          b ? {tag, " R4 R5 one width"} : {tag, " R3 R5 zero width"},
                          wid[p][j], e);
                    check(rise_at[p][j] == 1 + BIT * j, {tag, " R2 rise cycle"},
                          rise_at[p][j], 1 + BIT * j);
                end
            end
        end
    endtask

    task automatic quiet_span(input int n, input string tag);
        int bad;
        bad = 0;
        repeat (n) begin
            if (busy || led_out != '0) bad++;
            @(negedge clk);
        end
        check(bad == 0, tag, bad, 0);
    endtask

    initial begin
        rst        = 1'b1;
        run_en     = 1'b0;
        led_count  = '0;
        chain_mask = '0;
        wr_en      = 1'b0;
        wr_addr    = '0;
        wr_data    = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state at the ports
        check(led_out == '0, "R1 lines after reset", int'(led_out), 0);
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);

        // R9 nothing sent while run is low
        quiet_span(200, "R9 activity before run");

        // R1 cleared store: all ones on every chain
        led_count  = CW'(1);
        chain_mask = 8'hFF;
        run_en     = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R9 busy one cycle after run", int'(busy), 1);
        capture(-1, led_count, chain_mask, 1'b1);
        verify(1, 8'hFF, 24'h0, 1'b1, "R1");
        check(busy == 1'b1, "R8 frame period", int'(busy), 1);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            int cnt;
            int eff;
            cnt = int'(VECS[v][33:32]);
            eff = (cnt > MAXL) ? MAXL : cnt;
            stop_wait();
            load(VECS[v][23:0]);
            led_count  = CW'(cnt);
            chain_mask = VECS[v][31:24];
            run_en     = 1'b1;
            @(negedge clk);
            if (cnt == 0) begin
                quiet_span(2 * FRAME, "R11 zero count activity");
            end else begin
                check(busy == 1'b1, "R9 busy start", int'(busy), 1);
                capture(-1, led_count, chain_mask, 1'b1);
                verify(eff, VECS[v][31:24], VECS[v][23:0], 1'b0,
                       (cnt > MAXL) ? "R12" : "R5");
                check(busy == 1'b1, "R8 frame period", int'(busy), 1);
            end
        end

        // R10 mid-frame change of count and mask
        stop_wait();
        load(24'h3C3C3C);
        led_count  = CW'(2);
        chain_mask = 8'hFF;
        run_en     = 1'b1;
        @(negedge clk);
        capture(100, CW'(1), 8'h0F, 1'b1);
        verify(2, 8'hFF, 24'h3C3C3C, 1'b0, "R10 old frame");
        capture(-1, CW'(1), 8'h0F, 1'b1);
        verify(1, 8'h0F, 24'h3C3C3C, 1'b0, "R10 new frame");

        // R9 drop run mid-frame: frame completes, then idle
        capture(100, CW'(1), 8'h0F, 1'b0);
        verify(1, 8'h0F, 24'h3C3C3C, 1'b0, "R9 last frame");
        quiet_span(FRAME + 10, "R9 idle after stop");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule